// File: doc/BRIEF.md
# NAND Flash Bus Timing Sequencer

This block runs one access at a time on a byte-wide NAND flash bus from a single host clock. A host presents a request with an access kind (command byte, address byte, data write or data read), a byte to send, a bank number and six timing fields. When the block is idle it takes the request. It then steps through a fixed series of phases. A setup phase presents the latch-enable lines. Reads may add a delay phase. An active-strobe phase follows, and it is stretched while the flash holds its wait line low. A hold phase comes next. Last, a single-cycle completion pulse returns the captured read byte.

Each timing field is taken when the request is accepted and used unchanged until the access ends. Most fields count their stored value plus one cycle. The bus high-impedance delay counts exactly its stored value. The block remembers whether the last access was a command or an address byte, so that a following read gets the matching read-enable delay.

Top module: `nand_seq`

## Requirements
- R1: Out of reset and whenever idle, all four active-low chip enables (`nand_ce_no`) and both active-low strobes are high, CLE and ALE are low, the bus is not driven, and `ready_o` is high.
- R2: The `kind_i` codes are: 0 command write, 1 address write, 2 data write, 3 data read. After acceptance, a setup phase lasts `t_set_i`+1 cycles. During it, and through every later phase up to the end of hold, `nand_ce_no[b]` is low for the selected bank b and all other chip enables stay high. CLE is high for kind 0 and ALE is high for kind 1.
- R3: The strobe phase holds `nand_we_no` low for kinds 0, 1 and 2, and holds `nand_re_no` low for kind 3. It lasts `t_wait_i`+1 cycles in which `wait_ni` is high.
- R4: In any strobe cycle where `wait_ni` is low, the strobe count does not advance, so the strobe stays asserted one extra cycle for each such cycle.
- R5: A hold phase of `t_hold_i`+1 cycles follows the strobe. Both strobes are high, while chip enable, CLE/ALE and, on writes, the driven byte are kept.
- R6: On kinds 0 to 2, `nand_dq_oe_o` is low for the first `t_hiz_i` cycles after acceptance and high from then to the end of hold, with `nand_dq_o` equal to the accepted byte. On kind 3, `nand_dq_oe_o` is never high.
- R7: A read right after a command access inserts `t_clr_i`+1 cycles between setup and strobe. A read right after an address access inserts `t_ar_i`+1 cycles. Any other read inserts none.
- R8: On a read, `rdata_o` holds the `nand_dq_i` value sampled on the clock edge that ends the last strobe cycle, and it is valid while `done_o` is high.
- R9: After the hold phase, `done_o` is high for exactly one cycle with all pins idle, and the block is idle with `ready_o` high in the next cycle. A request seen while `ready_o` is low is ignored.
- R10: Changes to kind, bank, byte or timing inputs after acceptance have no effect on the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, taken when ready_o is high |
| ready_o | output | 1 | Idle, can accept a request |
| kind_i | input | 2 | Access kind: 0 cmd, 1 addr, 2 write, 3 read |
| bank_i | input | 2 | Bank select |
| wdata_i | input | 8 | Byte to drive on writes |
| t_clr_i | input | 4 | Read delay after a command, plus one |
| t_ar_i | input | 4 | Read delay after an address, plus one |
| t_hiz_i | input | 8 | Bus tristate cycles at the start of a write |
| t_hold_i | input | 8 | Hold cycles, plus one |
| t_wait_i | input | 8 | Strobe cycles, plus one |
| t_set_i | input | 8 | Setup cycles, plus one |
| wait_ni | input | 1 | Active-low wait from the flash |
| nand_dq_i | input | 8 | Bus data from the flash |
| nand_dq_o | output | 8 | Bus data to the flash |
| nand_dq_oe_o | output | 1 | Bus output enable |
| nand_ce_no | output | 4 | Active-low chip enable per bank |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Active-low write strobe |
| nand_re_no | output | 1 | Active-low read strobe |
| done_o | output | 1 | One-cycle access completion |
| rdata_o | output | 8 | Captured read byte |

## Verification
A wrong phase or a miscounted phase counter shows on the strobe and latch-enable pins in the very cycle the phase should have begun or ended. Comparing every pin on every clock therefore finds the error at once, not at `done_o`. A lost or wrong command/address history shows only on the next read, as a read-delay phase of the wrong length. A read capture taken one edge off shows as a wrong `rdata_o`, because the bench changes the flash data every cycle. A high-impedance counter error shows as a one-cycle shift in the output enable edge.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_WR   = 2'd2,
    KIND_RD   = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_RDLY,
    PH_STROBE,
    PH_HOLD,
    PH_DONE
  } phase_e;

endpackage

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/nand_hiz_gate.sv
module nand_hiz_gate #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             tick_i,
  output logic             open_o
);

  logic [CNT_W-1:0] left_q;

  // counts exact value, no plus-one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (load_i) begin
      left_q <= val_i;
    end else if (tick_i && (left_q != '0)) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign open_o = (left_q == '0);

endmodule

// File: rtl/nand_pin_decode.sv
module nand_pin_decode
  import nand_seq_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int BANK_W = 2
) (
  input  phase_e            phase_i,
  input  kind_e             kind_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              hiz_open_i,
  output logic [BANKS-1:0]  ce_no,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic              oe_o
);

  logic active;
  logic strobe;

  assign active = (phase_i == PH_SETUP) || (phase_i == PH_RDLY) ||
                  (phase_i == PH_STROBE) || (phase_i == PH_HOLD);
  assign strobe = (phase_i == PH_STROBE);

  for (genvar b = 0; b < BANKS; b++) begin : g_ce
    assign ce_no[b] = !(active && (bank_i == BANK_W'(b)));
  end

  assign cle_o = active && (kind_i == KIND_CMD);
  assign ale_o = active && (kind_i == KIND_ADDR);
  assign we_no = !(strobe && (kind_i != KIND_RD));
  assign re_no = !(strobe && (kind_i == KIND_RD));
  assign oe_o  = active && (kind_i != KIND_RD) && hiz_open_i;

endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BANKS   = 4,
  parameter int SHORT_W = 4,
  parameter int LONG_W  = 8,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  output logic               ready_o,
  input  logic [1:0]         kind_i,
  input  logic [BANK_W-1:0]  bank_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [SHORT_W-1:0] t_clr_i,
  input  logic [SHORT_W-1:0] t_ar_i,
  input  logic [LONG_W-1:0]  t_hiz_i,
  input  logic [LONG_W-1:0]  t_hold_i,
  input  logic [LONG_W-1:0]  t_wait_i,
  input  logic [LONG_W-1:0]  t_set_i,
  input  logic               wait_ni,
  input  logic [DATA_W-1:0]  nand_dq_i,
  output logic [DATA_W-1:0]  nand_dq_o,
  output logic               nand_dq_oe_o,
  output logic [BANKS-1:0]   nand_ce_no,
  output logic               nand_cle_o,
  output logic               nand_ale_o,
  output logic               nand_we_no,
  output logic               nand_re_no,
  output logic               done_o,
  output logic [DATA_W-1:0]  rdata_o
);

  phase_e             phase_q, phase_d;
  kind_e              kind_q;
  logic [BANK_W-1:0]  bank_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  rdata_q;
  logic [SHORT_W-1:0] clr_q, ar_q;
  logic [LONG_W-1:0]  hold_q, wait_q;
  logic               prev_cmd_q, prev_addr_q;

  logic               accept;
  logic               tmr_load;
  logic [LONG_W-1:0]  tmr_val;
  logic               tmr_run;
  logic               tmr_zero;
  logic               active;
  logic               strobe_last;
  logic               hold_last;
  logic               hiz_open;

  assign accept      = (phase_q == PH_IDLE) && req_i;
  assign active      = (phase_q == PH_SETUP) || (phase_q == PH_RDLY) ||
                       (phase_q == PH_STROBE) || (phase_q == PH_HOLD);
  assign tmr_run     = !((phase_q == PH_STROBE) && !wait_ni);
  assign strobe_last = (phase_q == PH_STROBE) && tmr_zero && wait_ni;
  assign hold_last   = (phase_q == PH_HOLD) && tmr_zero;

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_i) begin
          phase_d  = PH_SETUP;
          tmr_load = 1'b1;
          tmr_val  = t_set_i;
        end
      end
      PH_SETUP: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if ((kind_q == KIND_RD) && (prev_cmd_q || prev_addr_q)) begin
            phase_d = PH_RDLY;
            tmr_val = prev_cmd_q ? LONG_W'(clr_q) : LONG_W'(ar_q);
          end else begin
            phase_d = PH_STROBE;
            tmr_val = wait_q;
          end
        end
      end
      PH_RDLY: begin
        if (tmr_zero) begin
          phase_d  = PH_STROBE;
          tmr_load = 1'b1;
          tmr_val  = wait_q;
        end
      end
      PH_STROBE: begin
        if (strobe_last) begin
          phase_d  = PH_HOLD;
          tmr_load = 1'b1;
          tmr_val  = hold_q;
        end
      end
      PH_HOLD: begin
        if (tmr_zero) phase_d = PH_DONE;
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  // request fields frozen for the whole access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= KIND_CMD;
      bank_q  <= '0;
      wdata_q <= '0;
      clr_q   <= '0;
      ar_q    <= '0;
      hold_q  <= '0;
      wait_q  <= '0;
    end else if (accept) begin
      kind_q  <= kind_e'(kind_i);
      bank_q  <= bank_i;
      wdata_q <= wdata_i;
      clr_q   <= t_clr_i;
      ar_q    <= t_ar_i;
      hold_q  <= t_hold_i;
      wait_q  <= t_wait_i;
    end
  end

  // history of the last completed access, picks the read delay
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_cmd_q  <= 1'b0;
      prev_addr_q <= 1'b0;
    end else if (hold_last) begin
      prev_cmd_q  <= (kind_q == KIND_CMD);
      prev_addr_q <= (kind_q == KIND_ADDR);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (strobe_last && (kind_q == KIND_RD)) begin
      rdata_q <= nand_dq_i;
    end
  end

  nand_phase_timer #(
    .CNT_W (LONG_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .run_i      (tmr_run),
    .zero_o     (tmr_zero)
  );

  nand_hiz_gate #(
    .CNT_W (LONG_W)
  ) u_hiz (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .val_i  (t_hiz_i),
    .tick_i (active),
    .open_o (hiz_open)
  );

  nand_pin_decode #(
    .BANKS  (BANKS),
    .BANK_W (BANK_W)
  ) u_pins (
    .phase_i    (phase_q),
    .kind_i     (kind_q),
    .bank_i     (bank_q),
    .hiz_open_i (hiz_open),
    .ce_no      (nand_ce_no),
    .cle_o      (nand_cle_o),
    .ale_o      (nand_ale_o),
    .we_no      (nand_we_no),
    .re_no      (nand_re_no),
    .oe_o       (nand_dq_oe_o)
  );

  assign ready_o   = (phase_q == PH_IDLE);
  assign done_o    = (phase_q == PH_DONE);
  assign nand_dq_o = wdata_q;
  assign rdata_o   = rdata_q;

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
  parameter int BANKS = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wait_ni,
  input logic             ready_o,
  input logic             done_o,
  input logic [BANKS-1:0] nand_ce_no,
  input logic             nand_cle_o,
  input logic             nand_ale_o,
  input logic             nand_we_no,
  input logic             nand_re_no,
  input logic             nand_dq_oe_o
);

  p_idle_pins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (&nand_ce_no && !nand_cle_o && !nand_ale_o &&
                 nand_we_no && nand_re_no && !nand_dq_oe_o));

  p_ctl_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));

  p_ce_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~nand_ce_no));

  p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));

  p_strobe_ce_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> !(&nand_ce_no));

  p_we_stretch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no && !wait_ni) |=> !nand_we_no);

  p_re_stretch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_re_no && !wait_ni) |=> !nand_re_no);

  p_read_no_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_dq_oe_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ready_o));

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (&nand_ce_no && !ready_o));

endmodule

bind nand_seq nand_seq_chk #(.BANKS(BANKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wait_ni      (wait_ni),
  .ready_o      (ready_o),
  .done_o       (done_o),
  .nand_ce_no   (nand_ce_no),
  .nand_cle_o   (nand_cle_o),
  .nand_ale_o   (nand_ale_o),
  .nand_we_no   (nand_we_no),
  .nand_re_no   (nand_re_no),
  .nand_dq_oe_o (nand_dq_oe_o)
);

// File: tb/nand_seq_tb.sv
module nand_seq_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic       ready_o;
  logic [1:0] kind_i = 2'd0;
  logic [1:0] bank_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [3:0] t_clr_i = 4'd0;
  logic [3:0] t_ar_i = 4'd0;
  logic [7:0] t_hiz_i = 8'd0;
  logic [7:0] t_hold_i = 8'd0;
  logic [7:0] t_wait_i = 8'd0;
  logic [7:0] t_set_i = 8'd0;
  logic       wait_ni = 1'b1;
  logic [7:0] nand_dq_i = 8'd0;
  logic [7:0] nand_dq_o;
  logic       nand_dq_oe_o;
  logic [3:0] nand_ce_no;
  logic       nand_cle_o, nand_ale_o, nand_we_no, nand_re_no;
  logic       done_o;
  logic [7:0] rdata_o;

  int n_cmp = 0;
  int n_bad = 0;
  int prev_kind = -1;  // -1 none, else kind of last finished access

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  nand_seq u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .ready_o      (ready_o),
    .kind_i       (kind_i),
    .bank_i       (bank_i),
    .wdata_i      (wdata_i),
    .t_clr_i      (t_clr_i),
    .t_ar_i       (t_ar_i),
    .t_hiz_i      (t_hiz_i),
    .t_hold_i     (t_hold_i),
    .t_wait_i     (t_wait_i),
    .t_set_i      (t_set_i),
    .wait_ni      (wait_ni),
    .nand_dq_i    (nand_dq_i),
    .nand_dq_o    (nand_dq_o),
    .nand_dq_oe_o (nand_dq_oe_o),
    .nand_ce_no   (nand_ce_no),
    .nand_cle_o   (nand_cle_o),
    .nand_ale_o   (nand_ale_o),
    .nand_we_no   (nand_we_no),
    .nand_re_no   (nand_re_no),
    .done_o       (done_o),
    .rdata_o      (rdata_o)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // pins: ce, cle, ale, we, re, oe, done, ready
  task automatic cmp_pins(input string tag, input int ce, input int cle, input int ale,
                          input int we, input int re, input int oe, input int dn,
                          input int rdy);
    cmp({tag, " ce_n"},  int'(nand_ce_no), ce);
    cmp({tag, " cle"},   int'(nand_cle_o), cle);
    cmp({tag, " ale"},   int'(nand_ale_o), ale);
    cmp({tag, " we_n"},  int'(nand_we_no), we);
    cmp({tag, " re_n"},  int'(nand_re_no), re);
    cmp({tag, " oe"},    int'(nand_dq_oe_o), oe);
    cmp({tag, " done"},  int'(done_o), dn);
    cmp({tag, " ready"}, int'(ready_o), rdy);
  endtask

  task automatic run_access(input int kind, input int bank, input int data,
                            input int clr, input int ar, input int hiz, input int hold,
                            input int wt, input int set, input int wlow,
                            input bit scramble);
    int rdly, n_set, n_str, n_hold, s0, h0, total, cap_val;
    rdly = 0;
    if (kind == 3 && prev_kind == 0) rdly = clr + 1;       // R7 after command
    else if (kind == 3 && prev_kind == 1) rdly = ar + 1;   // R7 after address
    n_set  = set + 1;
    n_str  = wt + 1 + wlow;
    n_hold = hold + 1;
    s0     = n_set + rdly;
    h0     = s0 + n_str;
    total  = h0 + n_hold;
    cap_val = 0;

    kind_i = 2'(kind); bank_i = 2'(bank); wdata_i = 8'(data);
    t_clr_i = 4'(clr); t_ar_i = 4'(ar); t_hiz_i = 8'(hiz);
    t_hold_i = 8'(hold); t_wait_i = 8'(wt); t_set_i = 8'(set);
    req_i = 1'b1;
    @(posedge clk_i);
    for (int i = 0; i < total; i++) begin
      bit strobe;
      int ce, exp_oe;
      string tag;
      @(negedge clk_i);
      if (scramble && i == 0) begin  // R10 inputs change after acceptance
        kind_i = 2'(kind ^ 1); bank_i = 2'(bank + 1); wdata_i = ~8'(data);
        t_clr_i = 4'd15; t_ar_i = 4'd15; t_hiz_i = 8'd0;
        t_hold_i = 8'd40; t_wait_i = 8'd40; t_set_i = 8'd40;
      end
      strobe = (i >= s0) && (i < h0);
      ce = 15 & ~(1 << bank);
      exp_oe = (kind != 3 && i >= hiz) ? 1 : 0;
      if (i < n_set) tag = scramble ? "R10 setup" : "R2 setup";
      else if (i < s0) tag = "R7 read delay";
      else if (strobe) tag = (i - s0 < wlow) ? "R4 stretch" : "R3 strobe";
      else tag = scramble ? "R10 hold" : "R5 hold";
      cmp_pins(tag, ce, kind == 0 ? 1 : 0, kind == 1 ? 1 : 0,
               (strobe && kind != 3) ? 0 : 1, (strobe && kind == 3) ? 0 : 1,
               exp_oe, 0, 0);
      if (exp_oe == 1) cmp("R6 dq_o", int'(nand_dq_o), data & 8'hff);
      wait_ni = !(strobe && (i - s0) < wlow);
      nand_dq_i = 8'(i * 37 + 11);
      if (i == h0 - 1) cap_val = (i * 37 + 11) & 8'hff;
    end
    @(negedge clk_i);
    cmp_pins("R9 done", 15, 0, 0, 1, 1, 0, 1, 0);
    if (kind == 3) cmp("R8 rdata", int'(rdata_o), cap_val);
    wait_ni = 1'b1;
    @(negedge clk_i);
    cmp_pins("R9 back idle", 15, 0, 0, 1, 1, 0, 0, 1);
    req_i = 1'b0;
    @(negedge clk_i);
    cmp_pins("R9 stays idle", 15, 0, 0, 1, 1, 0, 0, 1);
    prev_kind = kind;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    cmp_pins("R1 in reset", 15, 0, 0, 1, 1, 0, 0, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cmp_pins("R1 after reset", 15, 0, 0, 1, 1, 0, 0, 1);

    // read with no history: no delay phase
    run_access(3, 0, 8'h00, 5, 6, 0, 1, 1, 0, 0, 1'b0);
    run_access(0, 1, 8'h70, 0, 0, 0, 0, 0, 0, 0, 1'b0);
    run_access(3, 2, 8'h00, 2, 9, 3, 0, 2, 1, 3, 1'b0);
    run_access(1, 2, 8'h3c, 0, 0, 2, 3, 1, 2, 0, 1'b0);
    run_access(3, 3, 8'h00, 9, 3, 0, 2, 0, 0, 1, 1'b0);
    run_access(3, 1, 8'h00, 9, 3, 5, 0, 3, 1, 0, 1'b0);
    run_access(2, 3, 8'ha5, 0, 0, 20, 1, 2, 1, 2, 1'b0);
    run_access(2, 0, 8'h5e, 0, 0, 4, 2, 3, 3, 1, 1'b1);
    run_access(0, 0, 8'h90, 0, 0, 1, 0, 0, 0, 0, 1'b0);
    run_access(3, 0, 8'h00, 15, 0, 0, 0, 0, 0, 0, 1'b0);
    run_access(2, 1, 8'hff, 0, 0, 0, 255, 255, 0, 4, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule